// File: doc/BRIEF.md
# Triangular Carrier and Multisampling Scheduler

This block generates the up/down counting carrier of a digital PWM modulator that uses double update and multisampling. An N-bit counter climbs by one from 0 to 2^N-1 and then descends by one back to 0, one step for each cycle in which the clock enable is high. The carrier, together with a flag that gives the direction of the most recent step, goes to the PWM comparator.

Three single-cycle strobes are derived from the carrier:
- **Update strobe.** Fires at every peak and every valley. It tells the modulator to load a new control voltage, so there are two updates per switching period.
- **Sampling trigger.** Fires at a fixed spacing of carrier steps on both the rising and the falling ramp, so the acquisition path receives SAMPLES_PER_PERIOD/2 samples per ramp.
- **Controller-execution strobe.** Fires a programmable number of sampling intervals before each update. It arrives one step after the sampling trigger it is tied to, so the controller works on the latest averaged data and still finishes before the update.

Top module: `tri_carrier_sched`

## Requirements
- R1: While reset is held and after it is released, the carrier reads 0 and the direction flag reads 0 (rising). With the enable low after reset, no strobe is asserted.
- R2: On each enabled step the carrier moves by exactly one. It runs 0, 1, …, 2^N-1, 2^N-2, …, 0, 1, … so that one full period is 2·(2^N-1) enabled steps.
- R3: While the enable is low the carrier and the direction flag keep their values.
- R4: The direction flag is 1 exactly when the last enabled step decremented the carrier. It becomes 1 on the step leaving 2^N-1 and becomes 0 on the step leaving 0.
- R5: The update strobe is high in an enabled cycle exactly when the carrier equals 0 or 2^N-1. This includes the value 0 present right after reset.
- R6: Let L = log2(2^N / (SAMPLES_PER_PERIOD/2)). The sampling trigger is high in an enabled cycle exactly when the low L bits of the carrier are all ones with the direction flag 0, or all zeros with the direction flag 1.
- R7: Between two consecutive update strobes, counting the trigger that coincides with the closing update, exactly SAMPLES_PER_PERIOD/2 sampling triggers occur.
- R8: Let D = EXEC_BACK·2^L. The execution strobe is high in an enabled cycle exactly when the previous enabled step left the carrier at 2^N-1-D with direction flag 0, or at D with direction flag 1. Each execution strobe therefore precedes the next update strobe by D-1 enabled steps.
- R9: When the enable is low, the update, sampling and execution strobes are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Clock enable; one carrier step per high cycle |
| carrier_o | output | CNT_W | Carrier value |
| dir_down_o | output | 1 | 1 when the last step decremented the carrier |
| update_o | output | 1 | Control-voltage update strobe (peak or valley) |
| sample_o | output | 1 | Sampling trigger strobe |
| exec_o | output | 1 | Controller-execution strobe |

## Verification
The hardest case is an execution strobe that is pending while the enable drops. The strobe must wait, unchanged, until the next enabled cycle, and the carrier must not move in between. The bench reaches this case by driving the enable with an irregular gap pattern plus one long idle stretch, over several full carrier periods of a reduced configuration. Gaps then land beside peaks, valleys, triggers and pending execution strobes. The bench also measures the trigger count per ramp and the step distance from each execution strobe to the following update.

// File: rtl/tri_sched_pkg.sv
// Shared types for the triangular carrier scheduler.
// Assumes: nothing beyond SystemVerilog packages.
package tri_sched_pkg;

    // Direction of the most recent carrier step.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

endpackage

// File: rtl/tri_carrier_core.sv
// Up/down accumulator holding the carrier and its direction latch.
// The slope for the next step is chosen from the present value: the top value
// forces a descent, zero forces an ascent, and any other value keeps the latch.
// Assumes: step_en is a clean clock enable; reset is synchronous, active low.
module tri_carrier_core
    import tri_sched_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    output logic [CNT_W-1:0] carrier_q,
    output dir_e             dir_q,
    output logic             at_top,
    output logic             at_bottom
);

    localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};

    dir_e dir_next;

    // Decode the turning points and resolve the latch for the next step.
    always_comb begin
        at_top    = (carrier_q == TOP_VAL);
        at_bottom = (carrier_q == '0);
        if (at_top) begin
            dir_next = DIR_DOWN;
        end else if (at_bottom) begin
            dir_next = DIR_UP;
        end else begin
            dir_next = dir_q;
        end
    end

    // Advance the carrier by the resolved slope on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carrier_q <= '0;
            dir_q     <= DIR_UP;
        end else if (step_en) begin
            dir_q <= dir_next;
            if (dir_next == DIR_DOWN) begin
                carrier_q <= carrier_q - 1'b1;
            end else begin
                carrier_q <= carrier_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tri_sample_decode.sv
// Sampling trigger decoder. Watches the low LOW_W bits of the carrier: all
// ones on the rising ramp, all zeros on the falling ramp. The ramp is taken
// from the direction register, which lags the latch decision by one step.
// Assumes: LOW_W < CNT_W. LOW_W == 0 means a trigger on every step.
module tri_sample_decode
    import tri_sched_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int LOW_W = 5
) (
    input  logic             step_en,
    input  logic [CNT_W-1:0] carrier,
    input  dir_e             dir_q,
    output logic             sample
);

    generate
        if (LOW_W == 0) begin : g_every_step
            logic unused_bits;
            // No low field: every enabled step is a sampling instant.
            always_comb begin
                unused_bits = ^{carrier, dir_q};
                sample      = step_en;
            end
        end else begin : g_low_field
            logic [LOW_W-1:0] low_bits;
            logic             unused_high;
            // Compare the low field against the pattern for the current ramp.
            always_comb begin
                low_bits    = carrier[LOW_W-1:0];
                unused_high = ^carrier[CNT_W-1:LOW_W];
                if (dir_q == DIR_UP) begin
                    sample = step_en & (&low_bits);
                end else begin
                    sample = step_en & ~(|low_bits);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tri_exec_sched.sv
// Controller-execution scheduler. Marks the sampling instant lying EXEC_DIST
// steps before the coming peak or valley, then releases the strobe on the
// following enabled cycle. A pending strobe waits through enable gaps.
// Assumes: 0 < EXEC_DIST < 2^CNT_W - 1.
module tri_exec_sched
    import tri_sched_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int EXEC_DIST = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [CNT_W-1:0] carrier,
    input  dir_e             dir_q,
    output logic             exec
);

    localparam logic [CNT_W-1:0] TOP_VAL    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] FALL_MARK  = CNT_W'(EXEC_DIST);
    localparam logic [CNT_W-1:0] RISE_MARK  = TOP_VAL - FALL_MARK;

    logic match;
    logic pending_q;

    // Select the mark for the current ramp and compare.
    always_comb begin
        if (dir_q == DIR_UP) begin
            match = (carrier == RISE_MARK);
        end else begin
            match = (carrier == FALL_MARK);
        end
    end

    // Delay the match by one enabled step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (step_en) begin
            pending_q <= match;
        end
    end

    // Release the delayed strobe only in an enabled cycle.
    always_comb begin
        exec = step_en & pending_q;
    end

endmodule

// File: rtl/tri_carrier_sched.sv
// Triangular carrier generator with update, sampling and execution strobes
// for a double-update, multisampling PWM modulator.
// Assumes: SAMPLES_PER_PERIOD/2 divides 2^CNT_W and is a power of two;
// EXEC_BACK sampling intervals fit inside one ramp.
module tri_carrier_sched
    import tri_sched_pkg::*;
#(
    parameter int CNT_W              = 12,
    parameter int SAMPLES_PER_PERIOD = 256,
    parameter int EXEC_BACK          = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    output logic [CNT_W-1:0] carrier_o,
    output logic             dir_down_o,
    output logic             update_o,
    output logic             sample_o,
    output logic             exec_o
);

    localparam int HALF_SAMPLES = SAMPLES_PER_PERIOD / 2;
    localparam int SAMPLE_SPAN  = (1 << CNT_W) / HALF_SAMPLES;
    localparam int LOW_W        = $clog2(SAMPLE_SPAN);
    localparam int EXEC_DIST    = EXEC_BACK * SAMPLE_SPAN;

    logic [CNT_W-1:0] carrier_q;
    dir_e             dir_q;
    logic             at_top;
    logic             at_bottom;
    logic             sample_w;
    logic             exec_w;

    tri_carrier_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .carrier_q (carrier_q),
        .dir_q     (dir_q),
        .at_top    (at_top),
        .at_bottom (at_bottom)
    );

    tri_sample_decode #(
        .CNT_W (CNT_W),
        .LOW_W (LOW_W)
    ) u_sample (
        .step_en (step_en),
        .carrier (carrier_q),
        .dir_q   (dir_q),
        .sample  (sample_w)
    );

    tri_exec_sched #(
        .CNT_W     (CNT_W),
        .EXEC_DIST (EXEC_DIST)
    ) u_exec (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .carrier (carrier_q),
        .dir_q   (dir_q),
        .exec    (exec_w)
    );

    // Drive the outputs; the update strobe marks each turning point.
    always_comb begin
        carrier_o  = carrier_q;
        dir_down_o = (dir_q == DIR_DOWN);
        update_o   = step_en & (at_top | at_bottom);
        sample_o   = sample_w;
        exec_o     = exec_w;
    end

endmodule

// File: rtl/tri_carrier_sched_chk.sv
// Property checker for tri_carrier_sched, attached by bind.
// Assumes: the same parameter values as the bound instance.
module tri_carrier_sched_chk #(
    parameter int CNT_W              = 12,
    parameter int SAMPLES_PER_PERIOD = 256,
    parameter int EXEC_BACK          = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_en,
    input logic [CNT_W-1:0] carrier_o,
    input logic             dir_down_o,
    input logic             update_o,
    input logic             sample_o,
    input logic             exec_o
);

    localparam int HALF_SAMPLES = SAMPLES_PER_PERIOD / 2;
    localparam int SAMPLE_SPAN  = (1 << CNT_W) / HALF_SAMPLES;
    localparam int LOW_W        = $clog2(SAMPLE_SPAN);
    localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};

    // Elaboration-time sanity of the configuration.
    initial begin
        AST_CFG_DIVIDES: assert (((1 << CNT_W) % HALF_SAMPLES) == 0); // R6
        AST_CFG_OFFSET: assert (EXEC_BACK * SAMPLE_SPAN < (1 << CNT_W) - 1); // R8
    end

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> ((carrier_o == $past(carrier_o) + 1'b1) ||
                     (carrier_o == $past(carrier_o) - 1'b1))); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(carrier_o) && $stable(dir_down_o))); // R3

    AST_TURN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && carrier_o == TOP_VAL) |=> dir_down_o); // R4

    AST_TURN_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && carrier_o == '0) |=> !dir_down_o); // R4

    AST_UPDATE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> (carrier_o == '0 || carrier_o == TOP_VAL)); // R5

    AST_SAMPLE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o && !dir_down_o) |-> (carrier_o % SAMPLE_SPAN == SAMPLE_SPAN - 1)); // R6

    AST_EXEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |=> !exec_o); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |-> !(update_o || sample_o || exec_o)); // R9

    logic unused_lowbits;
    always_comb unused_lowbits = (LOW_W < 0);

endmodule

bind tri_carrier_sched tri_carrier_sched_chk #(
    .CNT_W              (CNT_W),
    .SAMPLES_PER_PERIOD (SAMPLES_PER_PERIOD),
    .EXEC_BACK          (EXEC_BACK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .carrier_o  (carrier_o),
    .dir_down_o (dir_down_o),
    .update_o   (update_o),
    .sample_o   (sample_o),
    .exec_o     (exec_o)
);

// File: tb/tri_carrier_sched_bench.sv
// Sweep of a reduced configuration over several carrier periods, with an
// irregular enable pattern. The expected values are computed arithmetically
// from the count of enabled steps.
module tri_carrier_sched_bench;

    localparam int N     = 6;
    localparam int NMS   = 16;
    localparam int KBACK = 2;
    localparam int TOPV  = (1 << N) - 1;          // 63
    localparam int PER   = 2 * TOPV;              // 126
    localparam int SPAN  = (1 << N) / (NMS / 2);  // 8
    localparam int DIST  = KBACK * SPAN;          // 16

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_en = 1'b0;
    logic [N-1:0] carrier_o;
    logic         dir_down_o;
    logic         update_o;
    logic         sample_o;
    logic         exec_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    tri_carrier_sched #(
        .CNT_W              (N),
        .SAMPLES_PER_PERIOD (NMS),
        .EXEC_BACK          (KBACK)
    ) u_tri_carrier_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .carrier_o  (carrier_o),
        .dir_down_o (dir_down_o),
        .update_o   (update_o),
        .sample_o   (sample_o),
        .exec_o     (exec_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int car_of(input int s);
        int p = s % PER;
        return (p <= TOPV) ? p : PER - p;
    endfunction

    function automatic int dir_of(input int s);
        int p = s % PER;
        if (s == 0) return 0;
        return (p > TOPV || p == 0) ? 1 : 0;
    endfunction

    function automatic int mark_of(input int s);
        int c = car_of(s);
        int d = dir_of(s);
        return ((d == 0 && c == TOPV - DIST) || (d == 1 && c == DIST)) ? 1 : 0;
    endfunction

    function automatic int samp_of(input int s);
        int c = car_of(s);
        return (dir_of(s) == 0) ? ((c % SPAN) == SPAN - 1) : ((c % SPAN) == 0);
    endfunction

    initial begin : main
        int  steps;
        int  trig_cnt;
        bit  seen_upd;
        bit  exec_pend;
        int  exec_step;
        int  last_peak;
        bit  en;
        int  exp_upd;
        int  exp_smp;
        int  exp_exe;
        steps = 0; trig_cnt = 0; seen_upd = 0; exec_pend = 0;
        exec_step = 0; last_peak = -1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(carrier_o == 0, "R1 carrier in reset", int'(carrier_o), 0);
        check(dir_down_o == 0, "R1 dir in reset", int'(dir_down_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #5;
        check(carrier_o == 0 && dir_down_o == 0, "R1 state after reset", int'(carrier_o), 0);
        check(!update_o && !sample_o && !exec_o, "R1 strobes idle",
              int'({update_o, sample_o, exec_o}), 0);

        for (int i = 0; i < 520; i++) begin
            @(negedge clk);
            en = !((i % 7) == 3) && !(i >= 200 && i < 212) && !((i % 11) == 5);
            step_en = en;
            #5;
            exp_upd = en && (car_of(steps) == 0 || car_of(steps) == TOPV);
            exp_smp = en && samp_of(steps);
            exp_exe = en && steps > 0 && mark_of(steps - 1);
            check(int'(carrier_o) == car_of(steps), en ? "R2 carrier" : "R3 carrier hold",
                  int'(carrier_o), car_of(steps));
            check(int'(dir_down_o) == dir_of(steps), en ? "R4 direction" : "R3 direction hold",
                  int'(dir_down_o), dir_of(steps));
            check(int'(update_o) == exp_upd, en ? "R5 update" : "R9 update idle",
                  int'(update_o), exp_upd);
            check(int'(sample_o) == exp_smp, en ? "R6 sample" : "R9 sample idle",
                  int'(sample_o), exp_smp);
            check(int'(exec_o) == exp_exe, en ? "R8 exec" : "R9 exec idle",
                  int'(exec_o), exp_exe);

            if (en && sample_o) trig_cnt++;
            if (en && exec_o) begin
                exec_pend = 1'b1;
                exec_step = steps;
            end
            if (en && update_o) begin
                if (seen_upd) begin
                    check(trig_cnt == NMS / 2, "R7 triggers per ramp", trig_cnt, NMS / 2);
                end
                if (exec_pend) begin
                    check(steps - exec_step == DIST - 1, "R8 exec lead", steps - exec_step, DIST - 1);
                    exec_pend = 1'b0;
                end
                if (int'(carrier_o) == TOPV) begin
                    if (last_peak >= 0) begin
                        check(steps - last_peak == PER, "R2 period", steps - last_peak, PER);
                    end
                    last_peak = steps;
                end
                trig_cnt = 0;
                seen_upd = 1'b1;
            end
            @(posedge clk);
            if (en) steps++;
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule